// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a target on a two-wire SMBus segment. It holds a small bank of 8-bit control registers that the rest of the chip reads as one flat vector. A host reaches the bank only through block transfers. Each transfer names a starting register index. A write also carries a byte count. The target acknowledges every header byte before any data moves. The block oversamples SCL and SDA with the system clock. It pulls SDA low through a single output-enable and never drives the line high.

For a write, the host sends the write address, the index N, the count X and then X data bytes. These land in registers N, N+1, and so on. For a read, the host sends the write address and the index, then a repeated START and the read address. The target replies with a byte count taken from a dedicated count register, which the host may also write. It then streams registers from N upward until the host refuses a byte. One register slot is read-only and mirrors a status input.

Top module: `smb_blkreg_target`

## Requirements
- R1: The address byte 0xD2 (write) and 0xD3 (read) is acknowledged. Any other address byte is not acknowledged, and `sda_oe` stays low from then until the next START.
- R2: After 0xD2, the target acknowledges the index byte N, the count byte X and each of the first X data bytes. Data byte i is stored in register (N+i) mod NREG. Bits are sent MSB first, and an acknowledge is `sda_oe` high during the ninth SCL pulse.
- R3: A data byte past the first X of a write (including any byte when X = 0) is not acknowledged and not stored, and neither is any later byte of that transfer.
- R4: After 0xD2, N, a repeated START and an acknowledged 0xD3, the target sends the count byte and then registers (N+i) mod NREG for i = 0, 1, … It moves to the next byte when the host acknowledges and stops driving after a host not-acknowledge.
- R5: Only the low log2(NREG) bits of the index are used. The register pointer wraps from NREG-1 to 0 on both writes and reads.
- R6: Register 0 is read-only. It reads as `status_i`, and writes to it are acknowledged and have no effect.
- R7: The count returned on a read is the content of register NREG-1. That register is written like any other and resets to NREG.
- R8: After reset, `sda_oe` is low, register NREG-1 holds NREG and every other writable register holds 0.
- R9: START and STOP are SDA falling and rising edges while SCL is high. A START at any point restarts address reception. `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, the data line is pulled low |
| status_i | input | 8 | Value returned for read-only register 0 |
| regs_o | output | NREG*8 | All registers, register k at bits [8k+7:8k] |

## Verification
Writes are tried at starting indices inside the bank, past its end and across the wrap point. This separates wrong pointer arithmetic from wrong index masking. Counts of zero, counts below the number of bytes sent and counts equal to it expose any acknowledge of bytes beyond the limit. Reads of varying length, some starting at the read-only slot and some after the count register was rewritten, separate the count byte from the data stream. Wrong addresses and a START in the middle of a header show whether the target truly releases the line and restarts cleanly.

// File: rtl/smb_blkreg_target.sv
module smb_blkreg_target #(
  parameter int NREG = 8,
  parameter logic [6:0] DEV7 = 7'h69,
  parameter int RO_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [7:0]        status_i,
  output logic [NREG*8-1:0] regs_o
);
  localparam int AW = $clog2(NREG);
  localparam logic [AW-1:0] RO_P  = AW'(RO_IDX);
  localparam logic [AW-1:0] CNT_P = AW'(NREG - 1);
  localparam logic [7:0] CNT_RST  = 8'(NREG);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK, S_IGN} st_t;
  typedef enum logic [1:0] {B_ADDR, B_IDX, B_CNT, B_DATA} role_t;

  logic [2:0] scl_p, sda_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  wire scl_s = scl_p[1];
  wire scl_q = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_q = sda_p[2];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  st_t          st;
  role_t        role;
  logic [6:0]   sh;
  logic [2:0]   bitn;
  logic         got8, ack_q, to_tx;
  logic [AW-1:0] ptr;
  logic [7:0]   rem, tx;
  logic [7:0]   regs [NREG];

  wire [7:0] rx_byte = {sh, sda_s};
  wire [7:0] rd_cur  = (ptr == RO_P) ? status_i : regs[ptr];
  wire last_bit = (st == S_RX) && scl_rise && !got8 && (bitn == 3'd7);
  wire wr_en = last_bit && (role == B_DATA) && (rem != 8'd0) && (ptr != RO_P);

  assign sda_oe = (st == S_RACK) | ((st == S_TX) & ~tx[7]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; role <= B_ADDR; sh <= '0; bitn <= '0;
      got8 <= 1'b0; ack_q <= 1'b0; to_tx <= 1'b0;
      ptr <= '0; rem <= '0; tx <= '0;
    end else if (start_det) begin
      st <= S_RX; role <= B_ADDR; bitn <= '0; got8 <= 1'b0; ack_q <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE; got8 <= 1'b0; ack_q <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise && !got8) begin
            sh   <= rx_byte[6:0];
            bitn <= bitn + 3'd1;
            if (bitn == 3'd7) begin
              got8  <= 1'b1;
              to_tx <= 1'b0;
              case (role)
                B_ADDR: begin
                  if (rx_byte == {DEV7, 1'b0}) begin
                    ack_q <= 1'b1; role <= B_IDX;
                  end else if (rx_byte == {DEV7, 1'b1}) begin
                    ack_q <= 1'b1; to_tx <= 1'b1;
                  end else ack_q <= 1'b0;
                end
                B_IDX: begin
                  ptr <= rx_byte[AW-1:0]; ack_q <= 1'b1; role <= B_CNT;
                end
                B_CNT: begin
                  rem <= rx_byte; ack_q <= 1'b1; role <= B_DATA;
                end
                default: begin
                  if (rem != 8'd0) begin
                    ack_q <= 1'b1; rem <= rem - 8'd1; ptr <= ptr + 1'b1;
                  end else ack_q <= 1'b0;
                end
              endcase
            end
          end else if (scl_fall && got8) begin
            got8 <= 1'b0;
            st   <= ack_q ? S_RACK : S_IGN;
          end
        end
        S_RACK: if (scl_fall) begin
          ack_q <= 1'b0;
          bitn  <= '0;
          if (to_tx) begin
            st <= S_TX; tx <= (CNT_P == RO_P) ? status_i : regs[CNT_P];
          end else st <= S_RX;
        end
        S_TX: if (scl_fall) begin
          if (bitn == 3'd7) st <= S_TACK;
          else begin
            tx <= {tx[6:0], 1'b0}; bitn <= bitn + 3'd1;
          end
        end
        S_TACK: begin
          if (scl_rise) begin
            if (sda_s) st <= S_IGN;
            else begin
              tx <= rd_cur; ptr <= ptr + 1'b1; got8 <= 1'b1;
            end
          end else if (scl_fall && got8) begin
            got8 <= 1'b0; bitn <= '0; st <= S_TX;
          end
        end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= (i == NREG - 1) ? CNT_RST : 8'd0;
    end else if (wr_en) begin
      regs[ptr] <= rx_byte;
    end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    if (g == RO_IDX) begin : g_ro
      assign regs_o[g*8 +: 8] = status_i;
    end else begin : g_rw
      assign regs_o[g*8 +: 8] = regs[g];
    end
  end

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s); // R9
  AST_IGN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN) |-> !sda_oe); // R1
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ((rem != $past(rem)) && ($past(role) == B_DATA)) |-> (($past(rem) != 8'd0) && (rem == $past(rem) - 8'd1))); // R3
  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_det) |-> ((st == S_RX) && (role == B_ADDR) && !sda_oe)); // R9
endmodule

// File: tb/smb_blkreg_target_tb_top.sv
module smb_blkreg_target_tb_top;
  localparam int NREG = 8;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, host_sda = 1'b1;
  logic sda_oe;
  logic [7:0] status = 8'h5A;
  logic [NREG*8-1:0] regs_o;
  wire sda_line = host_sda & ~sda_oe;
  int n_run = 0, n_fail = 0, mon_err = 0;
  bit done = 1'b0;
  logic [7:0] mdl [NREG];

  always #10 clk = ~clk;

  smb_blkreg_target #(.NREG(NREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .status_i(status), .regs_o(regs_o));

  logic prev_scl = 1'b1, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && prev_scl && (sda_oe != prev_oe)) mon_err++;
    prev_scl = scl;
    prev_oe  = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input int idx);
    return (idx % NREG == 0) ? status : mdl[idx % NREG];
  endfunction

  task automatic hp; repeat (6) @(negedge clk); endtask

  task automatic bus_start;
    host_sda = 1'b1; hp; scl = 1'b1; hp; host_sda = 1'b0; hp; scl = 1'b0; hp;
  endtask

  task automatic bus_stop;
    host_sda = 1'b0; hp; scl = 1'b1; hp; host_sda = 1'b1; hp;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; hp; scl = 1'b1; hp; scl = 1'b0;
    end
    host_sda = 1'b1; hp; scl = 1'b1; hp;
    acked = !sda_line;
    scl = 1'b0;
  endtask

  task automatic recv_byte(input bit nack_it, output logic [7:0] b);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp; scl = 1'b1; hp; b[i] = sda_line; scl = 1'b0;
    end
    host_sda = nack_it; hp; scl = 1'b1; hp; scl = 1'b0;
    hp; host_sda = 1'b1;
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < NREG; i++)
      chk(regs_o[i*8 +: 8] == exp_rd(i), req, regs_o[i*8 +: 8], exp_rd(i));
  endtask

  task automatic blk_write(input int n, input int x, input int nsend);
    bit a;
    logic [7:0] d;
    bus_start;
    send_byte(8'hD2, a); chk(a, "R1 write address ack", a, 1);
    send_byte(8'(n), a); chk(a, "R2 index ack", a, 1);
    send_byte(8'(x), a); chk(a, "R2 count ack", a, 1);
    for (int i = 0; i < nsend; i++) begin
      d = 8'($urandom);
      send_byte(d, a);
      if (i < x) begin
        chk(a, "R2 data ack", a, 1);
        if ((n + i) % NREG != 0) mdl[(n + i) % NREG] = d;
      end else chk(!a, "R3 byte past count nacked", a, 0);
    end
    bus_stop;
    chk_regs("R2/R5/R6 register contents after write");
  endtask

  task automatic blk_read(input int n, input int k);
    bit a;
    logic [7:0] b;
    bus_start;
    send_byte(8'hD2, a); chk(a, "R1 write address ack", a, 1);
    send_byte(8'(n), a); chk(a, "R4 index ack", a, 1);
    bus_start;
    send_byte(8'hD3, a); chk(a, "R1 read address ack", a, 1);
    recv_byte(k == 0, b); chk(b == mdl[NREG-1], "R7 returned count", b, mdl[NREG-1]);
    for (int i = 0; i < k; i++) begin
      recv_byte(i == k - 1, b);
      chk(b == exp_rd(n + i), ((n + i) % NREG == 0) ? "R6 read-only slot" : "R4/R5 read data",
          b, exp_rd(n + i));
    end
    bus_stop;
  endtask

  task automatic bad_addr(input logic [7:0] adr);
    bit a;
    bus_start;
    send_byte(adr, a); chk(!a, "R1 foreign address nacked", a, 0);
    send_byte(8'h03, a); chk(!a, "R1 line released after mismatch", a, 0);
    send_byte(8'h01, a); chk(!a, "R1 line released after mismatch", a, 0);
    bus_stop;
    chk_regs("R1 registers untouched");
  endtask

  initial begin
    bit a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) mdl[i] = (i == NREG - 1) ? 8'(NREG) : 8'h00;
    hp; hp; rst_n = 1'b1; hp;
    chk(sda_oe == 1'b0, "R8 sda released after reset", sda_oe, 0);
    chk_regs("R8 reset values");

    bad_addr(8'hA4);
    bad_addr(8'hD0);
    blk_write(1, 3, 3);
    blk_read(1, 3);
    blk_write(6, 4, 4);
    blk_read(6, 4);
    blk_write(9, 2, 2);
    blk_read(9, 2);
    blk_write(2, 2, 4);
    blk_write(3, 0, 1);
    blk_write(7, 1, 1);
    blk_read(0, 3);
    status = 8'hC3;
    blk_write(0, 2, 2);
    blk_read(0, 2);
    blk_read(4, 0);

    bus_start;
    send_byte(8'hD2, a); send_byte(8'h02, a);
    bus_start;
    send_byte(8'hD2, a); chk(a, "R9 restart address ack", a, 1);
    send_byte(8'h05, a); send_byte(8'h01, a);
    send_byte(8'hE7, a); chk(a, "R9 data after restart", a, 1);
    mdl[5] = 8'hE7;
    bus_stop;
    chk_regs("R9 contents after restart");

    for (int t = 0; t < 24; t++) begin
      int n = int'($urandom % 12);
      int x = int'($urandom % 6);
      blk_write(n, x, x + int'($urandom % 2));
      blk_read(int'($urandom % 12), int'($urandom % 7));
      if (t == 12) status = 8'($urandom);
    end

    chk(mon_err == 0, "R9 sda_oe changed while SCL high", mon_err, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule